// File: doc/BRIEF.md
# Eight-Channel DAC Serial Command Decoder

This block is the digital front end of an eight-channel voltage DAC. A host shifts a 16-bit command word into it over a three-wire serial link: a clock, an active-low select and a data line. The link is oversampled by the block's system clock. When the select line returns high, the block decodes the 4-bit command field at the top of the word and acts on it. It can load one channel's code register, load every channel with the same code, put the device to sleep, or do nothing. Any command other than sleep also wakes the device.

Bits leave the top of the shift register on a serial output, so several devices can share one select line in a chain. To hold a device in a chain asleep, the host sends it the sleep command each time the chain is updated. The code width is a parameter: 10 bits by default, with an 8-bit option. In both cases the code sits just below the command field.

Top module: `octdac_top`

## Requirements
- R1: While reset is low, and right after it is applied, every channel code is zero, `sleep` is low and `sdo` is low.
- R2: Command values 4'h1 to 4'h8 load the data field into channel k = command-1 (channel k occupies `codes[k*CODE_W +: CODE_W]`). All other channels are left unchanged.
- R3: Command 4'hF loads the same data field into all eight channels.
- R4: Command 4'hE sets `sleep` high and leaves every channel code unchanged, whatever its data field holds.
- R5: Commands 4'h0 and 4'h9 to 4'hD leave every channel code unchanged.
- R6: Completing any command other than 4'hE drives `sleep` low, including the no-change commands. A repeated 4'hE keeps `sleep` high.
- R7: The word is 16 bits, MSB first. Bits [15:12] hold the command and bits [11:12-CODE_W] hold the data; the remaining low bits are ignored. A bit is taken on each rising edge of `sck` while `cs_n` is low. `sck` edges seen while `cs_n` is high shift nothing.
- R8: A frame of more than 16 bits is decoded from the last 16 bits shifted in.
- R9: `sdo` takes the MSB of the shift register on each falling edge of `sck` while `cs_n` is low. A device therefore repeats its input stream 16 bits later.
- R10: Channel codes and `sleep` change only at a rising edge of `cs_n`. Bits shifted with `cs_n` still low change neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial bit clock, synchronous to clk |
| cs_n | input | 1 | Active-low frame select; its rising edge commits the word |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, for chaining |
| sleep | output | 1 | High while the device is asleep |
| codes | output | 8*CODE_W | Channel codes; channel k at bits [k*CODE_W +: CODE_W] |

## Verification
The bench targets the wake path through the no-change commands. A decoder that wakes only on load commands would leave `sleep` high after a 4'hB or 4'h0 word. Repeated sleep commands and a sleep word that carries non-zero data are also tested. The second catches a decoder that writes the sleep word's data into a channel. Long frames and `sck` toggling with `cs_n` high are checked as well. A shifter that counts bits instead of keeping the last sixteen would load the wrong channel, and one that shifts while deselected would corrupt the word. A 32-bit chained frame checks that `sdo` repeats the earlier word exactly 16 bits later. It also checks that only the later word is applied locally.

// File: rtl/octdac_pkg.sv
`timescale 1ns/1ps
package octdac_pkg;
  localparam int WORD_W = 16;
  localparam int CMD_W  = 4;
  localparam int NUM_CH = 8;

  localparam logic [CMD_W-1:0] CMD_SLEEP = 4'hE;
  localparam logic [CMD_W-1:0] CMD_ALL   = 4'hF;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_ONE   = 2'd1,
    OP_ALL   = 2'd2,
    OP_SLEEP = 2'd3
  } op_e;
endpackage

// File: rtl/octdac_shifter.sv
`timescale 1ns/1ps
module octdac_shifter
  import octdac_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sck,
  input  logic         cs_n,
  input  logic         sdi,
  output logic [W-1:0] word,
  output logic         sdo,
  output logic         commit
);
  logic         sck_q, cs_q;
  logic [W-1:0] sr_q, sr_d;
  logic         sdo_q, sdo_d;
  logic         sck_rise, sck_fall;

  assign sck_rise = sck & ~sck_q;
  assign sck_fall = ~sck & sck_q;

  always_comb begin
    sr_d  = sr_q;
    sdo_d = sdo_q;
    if (!cs_n && sck_rise) sr_d  = {sr_q[W-2:0], sdi};
    if (!cs_n && sck_fall) sdo_d = sr_q[W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      sr_q  <= '0;
      sdo_q <= 1'b0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      sr_q  <= sr_d;
      sdo_q <= sdo_d;
    end
  end

  assign commit = cs_n & ~cs_q;
  assign word   = sr_q;
  assign sdo    = sdo_q;
endmodule

// File: rtl/octdac_decode.sv
`timescale 1ns/1ps
module octdac_decode
  import octdac_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic [WORD_W-1:0] word,
  output op_e               op,
  output logic [NUM_CH-1:0] ch_sel,
  output logic [CODE_W-1:0] data
);
  localparam int PAD_W = WORD_W - CMD_W - CODE_W;

  logic [CMD_W-1:0]  cmd;
  logic [NUM_CH-1:0] ch_hit;
  logic              pad_unused;

  assign cmd        = word[WORD_W-1 -: CMD_W];
  assign data       = word[WORD_W-CMD_W-1 -: CODE_W];
  assign pad_unused = ^word[PAD_W-1:0];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
    assign ch_hit[g] = (cmd == CMD_W'(g + 1));
  end

  always_comb begin
    op     = OP_HOLD;
    ch_sel = '0;
    if (cmd == CMD_SLEEP) begin
      op = OP_SLEEP;
    end else if (cmd == CMD_ALL) begin
      op     = OP_ALL;
      ch_sel = '1;
    end else if (|ch_hit) begin
      op     = OP_ONE;
      ch_sel = ch_hit;
    end
  end
endmodule

// File: rtl/octdac_bank.sv
`timescale 1ns/1ps
module octdac_bank
  import octdac_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     commit,
  input  logic [NUM_CH-1:0]        ch_sel,
  input  logic [CODE_W-1:0]        data,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic              wr_en;
    logic [CODE_W-1:0] code_q, code_d;

    assign wr_en = commit & ch_sel[g];

    always_comb begin
      code_d = code_q;
      if (wr_en) code_d = data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= code_d;
    end

    assign codes[g*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/octdac_top.sv
`timescale 1ns/1ps
module octdac_top
  import octdac_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sck,
  input  logic                     cs_n,
  input  logic                     sdi,
  output logic                     sdo,
  output logic                     sleep,
  output logic [NUM_CH*CODE_W-1:0] codes
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [WORD_W-1:0] shift_word;
  logic              commit;
  op_e               op;
  logic [NUM_CH-1:0] ch_sel;
  logic [CODE_W-1:0] data;
  logic              sleep_q, sleep_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  octdac_shifter #(.W(WORD_W)) u_shift (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .sck    (sck),
    .cs_n   (cs_n),
    .sdi    (sdi),
    .word   (shift_word),
    .sdo    (sdo),
    .commit (commit)
  );

  octdac_decode #(.CODE_W(CODE_W)) u_dec (
    .word   (shift_word),
    .op     (op),
    .ch_sel (ch_sel),
    .data   (data)
  );

  octdac_bank #(.CODE_W(CODE_W)) u_bank (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .commit (commit),
    .ch_sel (ch_sel),
    .data   (data),
    .codes  (codes)
  );

  always_comb begin
    sleep_d = sleep_q;
    if (commit) sleep_d = (op == OP_SLEEP);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) sleep_q <= 1'b0;
    else            sleep_q <= sleep_d;
  end

  assign sleep = sleep_q;
endmodule

// File: rtl/octdac_chk.sv
`timescale 1ns/1ps
module octdac_chk
  import octdac_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sck,
  input logic                     cs_n,
  input logic                     sdo,
  input logic                     sleep,
  input logic [NUM_CH*CODE_W-1:0] codes,
  input logic [WORD_W-1:0]        shift_word
);
  logic [CMD_W-1:0]         cmd_w;
  logic [NUM_CH*CODE_W-1:0] bcast_w;
  logic                     nochg_w;

  assign cmd_w   = shift_word[WORD_W-1 -: CMD_W];
  assign bcast_w = {NUM_CH{shift_word[WORD_W-CMD_W-1 -: CODE_W]}};
  assign nochg_w = (cmd_w == 4'h0) || (cmd_w >= 4'h9 && cmd_w <= 4'hD);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |-> (codes == '0 && !sleep && !sdo)); // R1

  AST_ALL_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n) && cmd_w == CMD_ALL) |=> (codes == $past(bcast_w))); // R3

  AST_SLEEP_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep) |-> ($past(cmd_w) == CMD_SLEEP)); // R4

  AST_SLEEP_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n) && cmd_w == CMD_SLEEP) |=> $stable(codes)); // R4

  AST_NOCHG_KEEPS_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n) && nochg_w) |=> $stable(codes)); // R5

  AST_WAKE_ON_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !$past(cs_n) && cmd_w != CMD_SLEEP) |=> !sleep); // R6

  AST_SDO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sck && $past(sck) && !cs_n) |=> $stable(sdo)); // R9

  AST_CODES_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_n && !$past(cs_n)) |=> $stable(codes)); // R10

  AST_SLEEP_ONLY_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_n && !$past(cs_n)) |=> $stable(sleep)); // R10
endmodule

bind octdac_top octdac_chk #(.CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sck        (sck),
  .cs_n       (cs_n),
  .sdo        (sdo),
  .sleep      (sleep),
  .codes      (codes),
  .shift_word (shift_word)
);

// File: tb/tb_octdac_top.sv
`timescale 1ns/1ps
module tb_octdac_top;
  localparam int CW = 10;
  localparam int NV = 20;

  logic clk, rst_n, sck, cs_n, sdi;
  logic sdo, sleep;
  logic [8*CW-1:0] codes;

  int n_chk  = 0;
  int n_fail = 0;
  logic [CW-1:0] mdl [8];
  logic          mdl_sleep;
  logic [31:0]   sdo_cap;

  // {command[3:0], data[9:0], expected sleep}
  localparam logic [14:0] VEC [NV] = '{
    {4'h1, 10'h155, 1'b0}, {4'h8, 10'h2AA, 1'b0}, {4'h4, 10'h3FF, 1'b0},
    {4'hF, 10'h123, 1'b0}, {4'h2, 10'h001, 1'b0}, {4'h3, 10'h0C7, 1'b0},
    {4'h5, 10'h246, 1'b0}, {4'h6, 10'h38E, 1'b0}, {4'h7, 10'h1B9, 1'b0},
    {4'hE, 10'h3C3, 1'b1}, {4'h0, 10'h0F0, 1'b0}, {4'hE, 10'h000, 1'b1},
    {4'hE, 10'h111, 1'b1}, {4'hB, 10'h2F0, 1'b0}, {4'hE, 10'h2F0, 1'b1},
    {4'h9, 10'h155, 1'b0}, {4'hE, 10'h155, 1'b1}, {4'hD, 10'h0AA, 1'b0},
    {4'hC, 10'h3FF, 1'b0}, {4'hA, 10'h200, 1'b0}
  };

  octdac_top #(.CODE_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
    .sdo(sdo), .sleep(sleep), .codes(codes)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [8*CW-1:0] packed_mdl();
    logic [8*CW-1:0] v;
    for (int k = 0; k < 8; k++) v[k*CW +: CW] = mdl[k];
    return v;
  endfunction

  task automatic check(input string tag, input logic [8*CW-1:0] act, input logic [8*CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic apply_cmd(input logic [3:0] c, input logic [CW-1:0] d);
    if (c >= 4'h1 && c <= 4'h8) mdl[c - 4'h1] = d;
    else if (c == 4'hF) for (int k = 0; k < 8; k++) mdl[k] = d;
    mdl_sleep = (c == 4'hE);
  endtask

  task automatic shift_bits(input logic [31:0] bits, input int n);
    cs_n = 1'b0;
    tick(1);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = bits[i];
      sck = 1'b0;
      tick(2);
      sdo_cap = {sdo_cap[30:0], sdo};
      sck = 1'b1;
      tick(2);
    end
    sck = 1'b0;
    tick(2);
  endtask

  task automatic raise_cs();
    cs_n = 1'b1;
    tick(3);
  endtask

  function automatic logic [15:0] mk(input logic [3:0] c, input logic [CW-1:0] d);
    return {c, d, 2'b00};
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    if (c == 4'hE) return "R4";
    if (c == 4'hF) return "R3";
    if (c >= 4'h1 && c <= 4'h8) return "R2";
    return "R5";
  endfunction

  initial begin : watchdog
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    sck = 1'b0; cs_n = 1'b1; sdi = 1'b0; rst_n = 1'b1; sdo_cap = '0;
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    mdl_sleep = 1'b0;
    #2 rst_n = 1'b0;
    tick(3);
    check("R1 codes", codes, '0);
    check("R1 sleep", {79'd0, sleep}, '0);
    check("R1 sdo", {79'd0, sdo}, '0);
    rst_n = 1'b1;
    tick(4);

    // Vector walk: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      logic [3:0]    c;
      logic [CW-1:0] d;
      c = VEC[v][14:11];
      d = VEC[v][10:1];
      shift_bits({16'h0, mk(c, d)}, 16);
      raise_cs();
      apply_cmd(c, d);
      check(tag_of(c), codes, packed_mdl());
      check("R6 sleep", {79'd0, sleep}, {79'd0, VEC[v][0]});
    end

    // R10: shifted word not applied while cs_n low
    shift_bits({16'h0, mk(4'h6, 10'h035)}, 16);
    check("R10 codes before commit", codes, packed_mdl());
    check("R10 sleep before commit", {79'd0, sleep}, {79'd0, mdl_sleep});
    raise_cs();
    apply_cmd(4'h6, 10'h035);
    check("R10 codes after commit", codes, packed_mdl());

    // R7: sck toggles with cs_n high shift nothing; an empty frame recommits
    sdi = 1'b1;
    for (int i = 0; i < 6; i++) begin
      sck = 1'b1; tick(2); sck = 1'b0; tick(2);
    end
    cs_n = 1'b0; tick(2);
    raise_cs();
    apply_cmd(4'h6, 10'h035);
    check("R7 deselected sck", codes, packed_mdl());

    // R8: 20-bit frame uses the last 16 bits
    shift_bits({12'h0, 4'b1010, mk(4'h7, 10'h2D2)}, 20);
    raise_cs();
    apply_cmd(4'h7, 10'h2D2);
    check("R8 long frame", codes, packed_mdl());

    // R9: 32-bit chained frame, sdo repeats the stream 16 bits late
    shift_bits({mk(4'h1, 10'h3A5), mk(4'h3, 10'h05A)}, 32);
    check("R9 sdo prior word", {64'd0, sdo_cap[31:16]}, {64'd0, mk(4'h7, 10'h2D2)});
    check("R9 sdo first word", {64'd0, sdo_cap[15:0]}, {64'd0, mk(4'h1, 10'h3A5)});
    raise_cs();
    apply_cmd(4'h3, 10'h05A);
    check("R8 chain last word", codes, packed_mdl());

    // R1: reset applied mid-run
    rst_n = 1'b0;
    tick(1);
    check("R1 reset again codes", codes, '0);
    check("R1 reset again sleep", {79'd0, sleep}, '0);
    rst_n = 1'b1;
    tick(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule